// File: doc/BRIEF.md
# Receive Ring Stop-Index Controller

This block tracks the receive side of a descriptor-ring DMA channel. The ring holds a power-of-two number of slots. Each slot is one descriptor, and a descriptor is a fixed number of bytes wide. Each time a frame-arrival strobe is accepted, the engine fills the slot the current pointer names and steps the pointer to the next slot. The host bounds how far the engine may go by writing a stop index. That index is compared only at the moment of a step. When a step lands the pointer on the stop slot, the ring counts as exhausted. The block then raises a descriptor-underflow reason and stalls until the host writes a new stop index.

Both indices are exchanged as byte offsets, which are the slot number times the descriptor size. An offset equal to the ring length wraps to slot 0. A full ring and an empty ring have the same index values, so only the underflow reason tells them apart. After an underflow, software recovers by writing the slot just before the current one. This drops the ring contents and re-opens every slot. Strobes that arrive while the channel is stalled are discarded and counted.

The interrupt side is a sticky reason register with write-one-to-clear, plus a mask. The request line is high while any unmasked reason is set.

Top module: `rxring_stopidx_ctrl`

## Requirements
- R1: After reset the current and stop offsets read 0, reason and mask read 0, `irq` is low and `drop_count` is 0.
- R2: Each accepted strobe advances the current slot by one, wrapping from the last slot to slot 0. Word 0 of the register port reads the current slot times the descriptor size (4 bytes by default).
- R3: Each accepted strobe sets reason bit 16 (receive done).
- R4: When a step lands the current slot on the stop slot, reason bit 13 (underflow) is set and the channel stalls. With the stop offset at its reset value, exactly as many strobes as there are slots are accepted before the stall.
- R5: While the channel is stalled, strobes are dropped. The current offset does not move, bit 16 is not set, and `drop_count` rises by one for each dropped strobe.
- R6: A write to word 1 sets the stop slot to (data / descriptor size) mod slots, and word 1 reads that slot times the descriptor size. Any such write ends a stall. Writing the slot before the current one after an underflow allows slots-minus-one further frames.
- R7: The stop slot is checked only on a step. Writing the stop offset equal to the current offset does not block the next frame.
- R8: When a stop write and an accepted strobe fall in the same cycle, the step is compared against the old stop slot.
- R9: Word 2 reads the reason register, which holds only bits 10 to 16. Writing word 2 clears each bit written as 1 and leaves the bits written as 0.
- R10: The error inputs `err_evt[0..4]` set reason bits 10, 11, 12, 14 and 15 respectively.
- R11: Word 3 is the mask, and only bits 10 to 16 can be written. `irq` is high exactly when some reason bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame arrival strobe |
| err_evt | input | 5 | Fatal error event pulses |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word select: 0 current, 1 stop, 2 reason, 3 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |
| drop_count | output | DROP_W | Count of strobes dropped while stalled |

## Verification
Every state change (current slot, stop slot, stall, reason, mask and drop count) is registered at the clock edge that samples the strobe or the write. Read data and `irq` follow that state combinationally, so each result is visible one cycle after its stimulus. The bench drives inputs on the falling edge and holds them for one full cycle. It reads results on the next falling edge, after the single intervening rising edge. The same-cycle case drives the strobe and the stop write in the same cycle, so both meet the same rising edge.

// File: rtl/rxring_pkg.sv
// Package: shared constants for the receive ring stop-index controller.
// Assumes a 32-bit register port with four word registers.
package rxring_pkg;

    // Register word selects
    localparam logic [1:0] REG_CUR    = 2'd0;
    localparam logic [1:0] REG_STOP   = 2'd1;
    localparam logic [1:0] REG_REASON = 2'd2;
    localparam logic [1:0] REG_MASK   = 2'd3;

    // Reason bit positions
    localparam int unsigned BIT_UFLOW = 13;
    localparam int unsigned BIT_DONE  = 16;

    // Number of fatal error sources and their reason bit positions
    localparam int unsigned N_FATAL = 5;
    localparam int unsigned FATAL_POS [N_FATAL] = '{10, 11, 12, 14, 15};

    // Implemented reason / mask bits
    localparam logic [31:0] REASON_VALID = 32'h0001_FC00;

endpackage

// File: rtl/rxring_ptr.sv
// Module: rxring_ptr
// Holds the current slot, the stop slot and the stall flag.
// A strobe is accepted when not stalled; the step is compared against the
// stop slot as held before this edge, so a same-cycle stop write acts later.
// Assumes SLOTS is a power of two so the slot counter wraps on its own.
module rxring_ptr #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              stop_we_i,
    input  logic [SLOT_W-1:0] stop_slot_i,
    output logic [SLOT_W-1:0] cur_o,
    output logic [SLOT_W-1:0] stop_o,
    output logic              accept_o,
    output logic              uflow_o,
    output logic              drop_o
);

    logic [SLOT_W-1:0] cur_q;
    logic [SLOT_W-1:0] stop_q;
    logic              stall_q;
    logic [SLOT_W-1:0] nxt;

    // Decide acceptance and whether the step meets the stop slot
    always_comb begin
        nxt      = cur_q + 1'b1;
        accept_o = frame_i && !stall_q;
        uflow_o  = accept_o && (nxt == stop_q);
        drop_o   = frame_i && stall_q;
    end

    // Step the current slot on each accepted strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_q <= '0;
        else if (accept_o) cur_q <= nxt;
    end

    // Load the stop slot from the register port
    always_ff @(posedge clk) begin
        if (!rst_n)         stop_q <= '0;
        else if (stop_we_i) stop_q <= stop_slot_i;
    end

    // Stall on underflow; any stop write releases it
    always_ff @(posedge clk) begin
        if (!rst_n)         stall_q <= 1'b0;
        else if (stop_we_i) stall_q <= 1'b0;
        else if (uflow_o)   stall_q <= 1'b1;
    end

    assign cur_o  = cur_q;
    assign stop_o = stop_q;

    AST_ADV_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (cur_q == SLOT_W'($past(cur_q) + 1'b1))); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && frame_i) |=> $stable(cur_q)); // R5
    AST_STALL_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_q) |-> (cur_q == stop_q)); // R4
    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_we_i |=> !stall_q); // R6

endmodule

// File: rtl/rxring_irq.sv
// Module: rxring_irq
// Sticky reason register with write-one-to-clear and an interrupt mask.
// A set event wins over a clear of the same bit in the same cycle.
// Assumes set_i carries only implemented bits.
module rxring_irq
    import rxring_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] set_i,
    input  logic        clr_we_i,
    input  logic        mask_we_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] reason_o,
    output logic [31:0] mask_o,
    output logic        irq_o
);

    logic [31:0] reason_q;
    logic [31:0] mask_q;
    logic [31:0] clr_bits;

    // Bits removed by a clear write this cycle
    always_comb clr_bits = clr_we_i ? wdata_i : 32'h0;

    // Accumulate reasons, drop cleared ones, keep only implemented bits
    always_ff @(posedge clk) begin
        if (!rst_n) reason_q <= '0;
        else        reason_q <= ((reason_q & ~clr_bits) | set_i) & REASON_VALID;
    end

    // Load the mask, keeping only implemented bits
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= wdata_i & REASON_VALID;
    end

    assign reason_o = reason_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(reason_q & mask_q);

    AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != 32'h0) |=> ((reason_q & $past(set_i)) == $past(set_i))); // R3
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && ((wdata_i & ~set_i) != 32'h0))
        |=> ((reason_q & $past(wdata_i & ~set_i)) == 32'h0)); // R9
    AST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((reason_q | mask_q) & ~REASON_VALID) == 32'h0); // R11

endmodule

// File: rtl/rxring_dropcnt.sv
// Module: rxring_dropcnt
// Counts strobes discarded during a stall; saturates at all ones.
module rxring_dropcnt #(
    parameter int unsigned DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drop_i,
    output logic [DROP_W-1:0] count_o
);

    logic [DROP_W-1:0] cnt_q;

    // Increment on each dropped strobe until full
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (drop_i && (~cnt_q != 0)) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_i && (~cnt_q != 0)) |=> (cnt_q == DROP_W'($past(cnt_q) + 1'b1))); // R5
    AST_NO_DROP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_i |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/rxring_stopidx_ctrl.sv
// Module: rxring_stopidx_ctrl (top)
// Receive ring slot tracker: register decode, byte-offset conversion,
// reason event mapping and the request output.
// Assumes SLOTS and DESC_BYTES are powers of two with both offsets within 32 bits.
module rxring_stopidx_ctrl
    import rxring_pkg::*;
#(
    parameter int unsigned SLOTS      = 8,
    parameter int unsigned DESC_BYTES = 4,
    parameter int unsigned DROP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [4:0]        err_evt,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic [DROP_W-1:0] drop_count
);

    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam int unsigned DB_SH  = $clog2(DESC_BYTES);

    logic [SLOT_W-1:0] cur_slot;
    logic [SLOT_W-1:0] stop_slot;
    logic              accept;
    logic              uflow;
    logic              drop;
    logic              stop_we;
    logic              clr_we;
    logic              mask_we;
    logic [31:0]       set_vec;
    logic [31:0]       err_vec;
    logic [31:0]       reason;
    logic [31:0]       mask;
    logic [31:0]       cur_ofs;
    logic [31:0]       stop_ofs;

    // Decode register writes
    always_comb begin
        stop_we = reg_we && (reg_addr == REG_STOP);
        clr_we  = reg_we && (reg_addr == REG_REASON);
        mask_we = reg_we && (reg_addr == REG_MASK);
    end

    // Map each fatal input onto its reason bit
    for (genvar g = 0; g < N_FATAL; g++) begin : g_fatal
        always_comb begin
            err_vec[FATAL_POS[g]] = err_evt[g];
        end
    end
    assign err_vec[9:0]   = '0;
    assign err_vec[13]    = 1'b0;
    assign err_vec[31:16] = '0;

    // Combine event sources into the reason set vector
    always_comb begin
        set_vec            = err_vec;
        set_vec[BIT_DONE]  = accept;
        set_vec[BIT_UFLOW] = uflow;
    end

    rxring_ptr #(.SLOTS(SLOTS)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_stb),
        .stop_we_i  (stop_we),
        .stop_slot_i(reg_wdata[DB_SH +: SLOT_W]),
        .cur_o      (cur_slot),
        .stop_o     (stop_slot),
        .accept_o   (accept),
        .uflow_o    (uflow),
        .drop_o     (drop)
    );

    rxring_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_we_i (clr_we),
        .mask_we_i(mask_we),
        .wdata_i  (reg_wdata),
        .reason_o (reason),
        .mask_o   (mask),
        .irq_o    (irq)
    );

    rxring_dropcnt #(.DROP_W(DROP_W)) u_drop (
        .clk    (clk),
        .rst_n  (rst_n),
        .drop_i (drop),
        .count_o(drop_count)
    );

    // Convert slots to byte offsets
    always_comb begin
        cur_ofs                    = '0;
        stop_ofs                   = '0;
        cur_ofs[DB_SH +: SLOT_W]   = cur_slot;
        stop_ofs[DB_SH +: SLOT_W]  = stop_slot;
    end

    // Read mux
    always_comb begin
        unique case (reg_addr)
            REG_CUR:    reg_rdata = cur_ofs;
            REG_STOP:   reg_rdata = stop_ofs;
            REG_REASON: reg_rdata = reason;
            default:    reg_rdata = mask;
        endcase
    end

    AST_UFLOW_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> reason[BIT_UFLOW]); // R4
    AST_FATAL_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[0] |=> reason[10]); // R10

endmodule

// File: tb/rxring_stopidx_ctrl_bench.sv
// Directed bench for rxring_stopidx_ctrl, default parameters (8 slots, 4 bytes).
module rxring_stopidx_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [4:0]  err_evt = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [7:0]  drop_count;

    int checks = 0;
    int fails  = 0;

    rxring_stopidx_ctrl u_rxring_stopidx_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .err_evt(err_evt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); chk("R1 cur", d, 0);
        rd(2'd1, d); chk("R1 stop", d, 0);
        rd(2'd2, d); chk("R1 reason", d, 0);
        rd(2'd3, d); chk("R1 mask", d, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 drop", 32'(drop_count), 0);
    endtask

    task automatic t_fill;
        logic [31:0] d;
        wr(2'd3, 32'h0001_FC00);
        frames(1);
        rd(2'd0, d); chk("R2 cur after one", d, 4);
        rd(2'd2, d); chk("R3 done bit", d, 32'h0001_0000);
        chk("R11 irq on done", 32'(irq), 1);
        wr(2'd2, 32'h0001_0000);
        rd(2'd2, d); chk("R9 cleared", d, 0);
        chk("R11 irq low", 32'(irq), 0);
        frames(6);
        rd(2'd0, d); chk("R2 cur after seven", d, 28);
        rd(2'd2, d); chk("R4 no uflow yet", d & 32'h2000, 0);
        frames(1);
        rd(2'd0, d); chk("R2 wrap to slot 0", d, 0);
        rd(2'd2, d); chk("R4 uflow set", d & 32'h2000, 32'h2000);
        wr(2'd2, 32'h0001_FC00);
        frames(3);
        rd(2'd0, d); chk("R5 cur held", d, 0);
        rd(2'd2, d); chk("R5 no done", d, 0);
        chk("R5 drop count", 32'(drop_count), 3);
    endtask

    task automatic t_resume;
        logic [31:0] d;
        wr(2'd1, 32'd28);
        rd(2'd1, d); chk("R6 stop readback", d, 28);
        frames(6);
        rd(2'd0, d); chk("R6 cur after six", d, 24);
        rd(2'd2, d); chk("R6 no uflow after six", d & 32'h2000, 0);
        frames(1);
        rd(2'd0, d); chk("R6 cur at stop", d, 28);
        rd(2'd2, d); chk("R6 uflow after seven", d & 32'h2000, 32'h2000);
        chk("R6 no drops", 32'(drop_count), 3);
    endtask

    task automatic t_stop_at_cur;
        logic [31:0] d;
        wr(2'd2, 32'h0001_FC00);
        wr(2'd1, 32'd28);
        frames(1);
        rd(2'd0, d); chk("R7 frame taken", d, 0);
        rd(2'd2, d); chk("R7 done no uflow", d, 32'h0001_0000);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        wr(2'd2, 32'h0001_FC00);
        frames(5);
        rd(2'd0, d); chk("R8 cur at five", d, 20);
        @(negedge clk);
        frame_stb = 1'b1; reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd24;
        @(negedge clk);
        frame_stb = 1'b0; reg_we = 1'b0;
        rd(2'd0, d); chk("R8 step taken", d, 24);
        rd(2'd2, d); chk("R8 old stop used", d & 32'h2000, 0);
        rd(2'd1, d); chk("R8 new stop stored", d, 24);
        frames(1);
        rd(2'd0, d); chk("R7 step past stop", d, 28);
        rd(2'd2, d); chk("R7 still no uflow", d & 32'h2000, 0);
    endtask

    task automatic t_offsets;
        logic [31:0] d;
        wr(2'd1, 32'd32);
        rd(2'd1, d); chk("R6 ring length wraps", d, 0);
        wr(2'd1, 32'h44);
        rd(2'd1, d); chk("R6 modulo slots", d, 4);
        wr(2'd1, 32'h1F);
        rd(2'd1, d); chk("R6 low bits ignored", d, 28);
    endtask

    task automatic t_errors;
        logic [31:0] d;
        wr(2'd3, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        @(negedge clk); err_evt = 5'b10101;
        @(negedge clk); err_evt = 5'b0;
        rd(2'd2, d); chk("R10 fatal mapping", d, 32'h0000_9400);
        chk("R11 masked off", 32'(irq), 0);
        wr(2'd3, 32'h0000_4000);
        chk("R11 other bit", 32'(irq), 0);
        wr(2'd3, 32'h0000_8000);
        chk("R11 unmasked", 32'(irq), 1);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R11 mask bits", d, 32'h0001_FC00);
        wr(2'd2, 32'h0000_0400);
        rd(2'd2, d); chk("R9 partial clear", d, 32'h0000_9000);
        @(negedge clk); err_evt = 5'b01010;
        @(negedge clk); err_evt = 5'b0;
        rd(2'd2, d); chk("R10 bits 11 and 14", d, 32'h0000_D800);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_resume();
        t_stop_at_cur();
        t_same_cycle();
        t_offsets();
        t_errors();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule